// File: doc/BRIEF.md
# Register Stack with Full/Empty Flags

A last-in first-out stack held in a small internal register file and addressed by a wrapping stack pointer. Each clock cycle a client may strobe one push or one pop. A push takes the word on the input bus. A pop copies the top word into an output data register, and the output bus shows that register.

The pointer moves before a write and after a read. The first pushed word therefore lands at address 1, and the word at address 0 is the last one filled. The stack is full when the pointer wraps back to zero after a push. It is empty when a pop brings the pointer back to zero. An illegal request is answered with a one-cycle reject pulse and changes nothing. Illegal requests are a push while full, a pop while empty, or a push and a pop in the same cycle.

Top module: `reg_stack`

## Requirements
- R1: While rst_ni is low and after its release, the pointer is 0, empty_o is 1, full_o is 0, data_o is 0 and reject_o is 0.
- R2: An accepted push (push_i high, pop_i low, full_o low) increments the pointer and then writes data_i to the word the new pointer addresses, so words come back in reverse order of pushing.
- R3: An accepted push clears empty_o from the next cycle. With PTR_W=6, full_o rises in the cycle after the 64th net push, when the pointer wraps to 0.
- R4: An accepted pop (pop_i high, push_i low, empty_o low) loads the data register from the word at the current pointer, then decrements the pointer. It clears full_o, and it sets empty_o when the pointer reaches 0.
- R5: A push while full_o is 1, or a pop while empty_o is 1, leaves the pointer, the stored words, full_o, empty_o and data_o unchanged, and reject_o is 1 in the following cycle.
- R6: full_o and empty_o are never 1 together.
- R7: push_i and pop_i high in the same cycle are both ignored, with no change to state or data_o, and reject_o is 1 in the following cycle.
- R8: data_o changes only at the clock edge of an accepted pop. It holds through pushes, idle cycles and rejected requests.
- R9: reject_o is 0 in the cycle after an idle cycle or an accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push request strobe |
| pop_i | input | 1 | Pop request strobe |
| data_i | input | DATA_W | Word to push |
| data_o | output | DATA_W | Data register, loaded by pops |
| full_o | output | 1 | Stack full flag |
| empty_o | output | 1 | Stack empty flag |
| reject_o | output | 1 | One-cycle pulse after an illegal request |

## Verification
The bench builds the block with its defaults, DATA_W=8 and PTR_W=6. At a depth of 64 the pointer wrap that sets full can be reached in a short directed fill, and so can the return to zero that sets empty. A random run of a few thousand cycles then crosses both boundaries many times. Overflow pushes, underflow pops and simultaneous requests are driven at every fill level against a queue-based model.

// File: rtl/reg_stack_pkg.sv
package reg_stack_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2,
    OP_REJ  = 2'd3
  } stk_op_e;
endpackage

// File: rtl/reg_stack_ctrl.sv
module reg_stack_ctrl
  import reg_stack_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    push_i,
  input  logic    pop_i,
  input  logic    full_i,
  input  logic    empty_i,
  output stk_op_e op_o,
  output logic    reject_o
);
  logic push_ok, pop_ok, rej_d, rej_q;

  always_comb begin
    push_ok = push_i & ~pop_i & ~full_i;
    pop_ok  = pop_i & ~push_i & ~empty_i;
    rej_d   = (push_i | pop_i) & ~push_ok & ~pop_ok;
    if (push_ok)     op_o = OP_PUSH;
    else if (pop_ok) op_o = OP_POP;
    else if (rej_d)  op_o = OP_REJ;
    else             op_o = OP_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rej_q <= 1'b0;
    else         rej_q <= rej_d;
  end

  assign reject_o = rej_q;
endmodule

// File: rtl/reg_stack_ptr.sv
module reg_stack_ptr
  import reg_stack_pkg::*;
#(
  parameter int unsigned PTR_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  stk_op_e          op_i,
  output logic [PTR_W-1:0] rd_addr_o,
  output logic [PTR_W-1:0] wr_addr_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [PTR_W-1:0] sp_q, sp_inc, sp_dec;
  logic             full_q, empty_q;

  assign sp_inc = sp_q + PTR_W'(1);
  assign sp_dec = sp_q - PTR_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q    <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
    end else begin
      unique case (op_i)
        OP_PUSH: begin
          sp_q    <= sp_inc;
          empty_q <= 1'b0;
          if (sp_inc == '0) full_q <= 1'b1;  // wrap marks full
        end
        OP_POP: begin
          sp_q   <= sp_dec;
          full_q <= 1'b0;
          if (sp_dec == '0) empty_q <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign rd_addr_o = sp_q;
  assign wr_addr_o = sp_inc;
  assign full_o    = full_q;
  assign empty_o   = empty_q;
endmodule

// File: rtl/reg_stack_file.sv
module reg_stack_file
  import reg_stack_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned PTR_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  stk_op_e           op_i,
  input  logic [PTR_W-1:0]  wr_addr_i,
  input  logic [PTR_W-1:0]  rd_addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] dr_o
);
  localparam int unsigned DEPTH = 1 << PTR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] dr_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk_i) begin
      if (op_i == OP_PUSH && wr_addr_i == PTR_W'(g)) mem_q[g] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              dr_q <= '0;
    else if (op_i == OP_POP)  dr_q <= mem_q[rd_addr_i];
  end

  assign dr_o = dr_q;
endmodule

// File: rtl/reg_stack.sv
module reg_stack
  import reg_stack_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned PTR_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o,
  output logic              empty_o,
  output logic              reject_o
);
  stk_op_e          op;
  logic [PTR_W-1:0] rd_addr, wr_addr;
  logic             full, empty;

  reg_stack_ctrl i_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .push_i   (push_i),
    .pop_i    (pop_i),
    .full_i   (full),
    .empty_i  (empty),
    .op_o     (op),
    .reject_o (reject_o)
  );

  reg_stack_ptr #(.PTR_W(PTR_W)) i_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .op_i      (op),
    .rd_addr_o (rd_addr),
    .wr_addr_o (wr_addr),
    .full_o    (full),
    .empty_o   (empty)
  );

  reg_stack_file #(.DATA_W(DATA_W), .PTR_W(PTR_W)) i_file (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .op_i      (op),
    .wr_addr_i (wr_addr),
    .rd_addr_i (rd_addr),
    .wdata_i   (data_i),
    .dr_o      (data_o)
  );

  assign full_o  = full;
  assign empty_o = empty;
endmodule

// File: rtl/reg_stack_chk.sv
module reg_stack_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              push_i,
  input logic              pop_i,
  input logic [DATA_W-1:0] data_o,
  input logic              full_o,
  input logic              empty_o,
  input logic              reject_o
);
  AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o)); // R6

  AST_PUSH_CLR_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && !full_o) |=> !empty_o); // R3

  AST_POP_CLR_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && !empty_o) |=> !full_o); // R4

  AST_REJ_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && full_o) |=> (reject_o && full_o && $stable(data_o))); // R5

  AST_REJ_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && empty_o) |=> (reject_o && empty_o && $stable(data_o))); // R5

  AST_REJ_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i) |=> (reject_o && $stable(full_o) && $stable(empty_o) && $stable(data_o))); // R7

  AST_DOUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pop_i && !push_i && !empty_o) |=> $stable(data_o)); // R8

  AST_NO_SPURIOUS_REJ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_i || pop_i) |=> !reject_o); // R9
endmodule

bind reg_stack reg_stack_chk #(.DATA_W(DATA_W)) i_reg_stack_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .push_i   (push_i),
  .pop_i    (pop_i),
  .data_o   (data_o),
  .full_o   (full_o),
  .empty_o  (empty_o),
  .reject_o (reject_o)
);

// File: tb/test_reg_stack.sv
module test_reg_stack;
  localparam int DATA_W = 8;
  localparam int PTR_W  = 6;
  localparam int DEPTH  = 1 << PTR_W;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              push_i = 1'b0, pop_i = 1'b0;
  logic [DATA_W-1:0] data_i = '0;
  logic [DATA_W-1:0] data_o;
  logic              full_o, empty_o, reject_o;

  int errors = 0, checks = 0, cycles = 0;
  int q[$];
  int m_dout = 0;
  bit m_rej = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  reg_stack #(.DATA_W(DATA_W), .PTR_W(PTR_W)) i_reg_stack (
    .clk_i(clk), .rst_ni(rst_ni), .push_i(push_i), .pop_i(pop_i),
    .data_i(data_i), .data_o(data_o), .full_o(full_o),
    .empty_o(empty_o), .reject_o(reject_o));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare(input string req);
    chk(req, "data_o", int'(data_o), m_dout);
    chk(req, "full_o", int'(full_o), int'(q.size() == DEPTH));
    chk(req, "empty_o", int'(empty_o), int'(q.size() == 0));
    chk(req, "reject_o", int'(reject_o), int'(m_rej));
    chk("R6", "flags exclusive", int'(full_o && empty_o), 0);
  endtask

  // one cycle: drive at negedge, model at posedge, compare at next negedge
  task automatic step(input bit ps, input bit pp, input int d, input string req);
    bit push_ok, pop_ok;
    push_i = ps; pop_i = pp; data_i = DATA_W'(d);
    @(posedge clk);
    push_ok = ps && !pp && q.size() < DEPTH;
    pop_ok  = pp && !ps && q.size() > 0;
    m_rej   = (ps || pp) && !push_ok && !pop_ok;
    if (push_ok) q.push_back(d & ((1 << DATA_W) - 1));
    if (pop_ok)  m_dout = q.pop_back();
    @(negedge clk);
    cycles++;
    compare(req);
  endtask

  always @(posedge clk) begin
    if (!done && cycles > 200000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    compare("R1");  // during reset
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    compare("R1");

    step(0, 1, 0, "R5");      // pop on empty
    step(0, 0, 0, "R9");
    step(1, 0, 8'h11, "R2");
    step(1, 0, 8'h22, "R3");
    step(1, 0, 8'h33, "R8");  // push leaves data_o
    step(1, 1, 8'h44, "R7");
    step(0, 1, 0, "R4");      // 0x33
    step(0, 1, 0, "R2");      // 0x22
    step(0, 0, 0, "R8");
    step(0, 1, 0, "R4");      // 0x11, empty again
    step(0, 1, 0, "R5");

    for (int i = 0; i < DEPTH; i++) step(1, 0, 8'h80 + i, "R3");
    step(1, 0, 8'hEE, "R5");  // overflow
    step(1, 1, 8'hEF, "R7");
    step(0, 0, 0, "R9");
    for (int i = 0; i < DEPTH; i++) step(0, 1, 0, "R4");
    step(0, 1, 0, "R5");      // underflow

    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      bit ps = (r < 45) || (r >= 95);
      bit pp = (r >= 45 && r < 85) || (r >= 95);
      if (i >= 1500 && i < 2200) begin ps = (r < 80); pp = (r >= 80); end
      if (i >= 2200 && i < 2900) begin ps = (r < 20); pp = (r >= 20); end
      step(ps, pp, int'($urandom_range(0, 255)), "R6");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule